// File: doc/BRIEF.md
# SD Card SPI-Mode Transaction Sequencer

This block runs complete SD-card operations over an SPI link that moves one byte at a time. A host programs a small byte-wide register bank. It chooses an operation, loads a 32-bit card address one byte per register, sets the start bit, and then polls the busy flag. The block then drives the whole exchange: it builds command frames, polls for responses, frames and checks data tokens, and waits out card busy. An external shifter performs each byte exchange. It receives a byte with a one-cycle `spi_go` strobe and returns the byte it received with a one-cycle `spi_done` strobe.

Four operations are available: a raw single-byte transfer, card initialisation, a 512-byte block write and a 512-byte block read. Block write data comes from an external transmit FIFO through a pop handshake. Block read data goes to an external receive FIFO through a push strobe. Each operation class has its own 2-bit result field in a shared error register. Every wait is bounded by a polling limit, so a silent card cannot hang the block.

Top module: `sd_spi_seq`

## Requirements
- R1: While reset is applied and after it is released, the block is idle. Status (address 2) bit 0 reads 0, `spi_cs_n` is 1, the error register (address 3) reads 0 and `spi_clk_div` is 0.
- R2: Registers read back what was last written, and `spi_clk_div` follows the register at address 4. The registers are:
  - address 4: clock divider;
  - address 5: direct byte;
  - addresses 8 to 11: card address bytes, least significant byte first;
  - address 0: operation select, bits 1:0 only, where 0 is direct, 1 is init, 2 is write and 3 is read.
  Address 1 reads 0.
- R3: Writing a byte with bit 0 set to address 1 while idle starts the selected operation, and status bit 0 reads 1 from the next cycle until the operation ends. A start written while busy is ignored.
- R4: A direct operation exchanges exactly one byte, equal to the direct byte register, and leaves the error register unchanged.
- R5: A command is a 6-byte frame, and `spi_cs_n` stays 0 for the whole operation. The frame bytes are:
  - byte 1: 0x40 plus the command index (0 for init, 24 for write, 17 for read);
  - bytes 2 to 5: the argument, most significant byte first (zero for init, the card address otherwise);
  - byte 6: 0x95 for init, 0xFF otherwise.
  Response polling sends 0xFF.
- R6: Init resends its command frame each time the card answers 0x01, and ends with code 0 in error bits 1:0 on 0x00. Any other non-0xFF answer gives code 2. A 0x01 answer to the eighth frame gives code 3.
- R7: After 16 consecutive 0xFF bytes while polling for a command response or a read start token, the operation ends with code 1 in its own field.
- R8: Block write sends the following, then polls for a data response:
  - 0xFE right after a 0x00 command response;
  - 512 bytes popped from the transmit FIFO, in order;
  - two 0xFF bytes.
  A response whose low five bits are 00101 is accepted. Any other non-0xFF response gives code 3 in bits 5:4, and a non-zero command response gives code 2.
- R9: After an accepted write, the block keeps sending 0xFF while the card returns 0x00. It ends with code 0 at the first non-zero byte, or with code 1 after 32 zero bytes (bench setting).
- R10: Block read gets a 0x00 command response and polls for a 0xFE token. It then pushes the next 512 received bytes to the receive FIFO and discards two further bytes, with code 0 in bits 3:2. Any other non-0xFF token byte gives code 3.
- R11: Each operation writes only its own error field (init bits 1:0, read bits 3:2, write bits 5:4), and does so only when it ends.
- R12: While the transmit FIFO is empty during block write, no byte is issued and no pop occurs. The transfer resumes when data is available.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| spi_cs_n | output | 1 | Card select, active low |
| spi_clk_div | output | 8 | SPI clock divider setting for the shifter |
| spi_go | output | 1 | Start one byte exchange |
| spi_tx | output | 8 | Byte to send, valid with `spi_go` |
| spi_done | input | 1 | Byte exchange finished |
| spi_rx | input | 8 | Received byte, valid with `spi_done` |
| txf_empty | input | 1 | Transmit FIFO has no data |
| txf_data | input | 8 | Transmit FIFO head byte |
| txf_pop | output | 1 | Remove the head byte of the transmit FIFO |
| rxf_push | output | 1 | Write `rxf_data` into the receive FIFO |
| rxf_data | output | 8 | Byte for the receive FIFO |

## Verification
The bench drives a scripted card that answers each exchanged byte according to its position in the transaction. This lets it place responses, tokens and busy periods exactly on the byte the sequencer should be polling.

- Init retry and retry exhaustion: an off-by-one in the retry counter would send seven or nine frames instead of eight.
- Write data response with non-zero upper bits: a design that compares the whole byte against 0x05 would report a data error for a response the card accepted.
- Write busy-wait timeout.
- Read error tokens: a design that did not take every non-0xFF token byte as an error would wait for the token until it timed out.
- Transmit FIFO underflow stall: a design that ignored the empty flag would pop and send stale bytes.
- Start while busy: a design that accepted it would restart the operation, and the byte count would come out wrong.
- Error fields: each operation is checked for writing only its own field, so an error left in one field must survive the later operations.

// File: rtl/sd_spi_seq_pkg.sv
`timescale 1ns/1ps
package sd_spi_seq_pkg;

  typedef enum logic [1:0] {
    OP_DIRECT = 2'd0,
    OP_INIT   = 2'd1,
    OP_WRITE  = 2'd2,
    OP_READ   = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_DIRECT, S_CMD, S_RESP, S_WTOK, S_WDATA, S_WCRC,
    S_WDRESP, S_WBUSY, S_RTOK, S_RDATA, S_RCRC
  } st_e;

  localparam logic [3:0] RA_TYPE  = 4'd0;
  localparam logic [3:0] RA_CTRL  = 4'd1;
  localparam logic [3:0] RA_STAT  = 4'd2;
  localparam logic [3:0] RA_ERR   = 4'd3;
  localparam logic [3:0] RA_CDIV  = 4'd4;
  localparam logic [3:0] RA_DBYTE = 4'd5;
  localparam logic [3:0] RA_ADR0  = 4'd8;
  localparam logic [3:0] RA_ADR1  = 4'd9;
  localparam logic [3:0] RA_ADR2  = 4'd10;
  localparam logic [3:0] RA_ADR3  = 4'd11;

  localparam logic [1:0] EC_OK      = 2'd0;
  localparam logic [1:0] EC_TIMEOUT = 2'd1;
  localparam logic [1:0] EC_REJECT  = 2'd2;
  localparam logic [1:0] EC_DATA    = 2'd3;

  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] DATA_TOKEN = 8'hFE;
  localparam logic [7:0] RESP_READY = 8'h00;
  localparam logic [7:0] RESP_IDLE  = 8'h01;

endpackage

// File: rtl/sd_spi_seq_regs.sv
`timescale 1ns/1ps
module sd_spi_seq_regs
  import sd_spi_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [3:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        busy,
  input  logic        err_we,
  input  op_e         err_op,
  input  logic [1:0]  err_code,
  output op_e         op_type,
  output logic [31:0] card_addr,
  output logic [7:0]  clk_div,
  output logic [7:0]  dbyte,
  output logic        start,
  output logic [5:0]  err_q
);

  op_e         type_q, type_n;
  logic [31:0] adr_q, adr_n;
  logic [7:0]  cdiv_q, cdiv_n, db_q, db_n;
  logic [5:0]  err_n;

  assign start = we && (addr == RA_CTRL) && wdata[0] && !busy;

  always_comb begin
    type_n = type_q;
    adr_n  = adr_q;
    cdiv_n = cdiv_q;
    db_n   = db_q;
    err_n  = err_q;
    if (we) begin
      case (addr)
        RA_TYPE:  type_n = op_e'(wdata[1:0]);
        RA_CDIV:  cdiv_n = wdata;
        RA_DBYTE: db_n   = wdata;
        RA_ADR0:  adr_n[7:0]   = wdata;
        RA_ADR1:  adr_n[15:8]  = wdata;
        RA_ADR2:  adr_n[23:16] = wdata;
        RA_ADR3:  adr_n[31:24] = wdata;
        default:  ;
      endcase
    end
    if (err_we) begin
      case (err_op)
        OP_INIT:  err_n[1:0] = err_code;
        OP_READ:  err_n[3:2] = err_code;
        OP_WRITE: err_n[5:4] = err_code;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= OP_DIRECT;
      adr_q  <= '0;
      cdiv_q <= '0;
      db_q   <= '0;
      err_q  <= '0;
    end else begin
      type_q <= type_n;
      adr_q  <= adr_n;
      cdiv_q <= cdiv_n;
      db_q   <= db_n;
      err_q  <= err_n;
    end
  end

  always_comb begin
    case (addr)
      RA_TYPE:  rdata = {6'd0, type_q};
      RA_STAT:  rdata = {7'd0, busy};
      RA_ERR:   rdata = {2'd0, err_q};
      RA_CDIV:  rdata = cdiv_q;
      RA_DBYTE: rdata = db_q;
      RA_ADR0:  rdata = adr_q[7:0];
      RA_ADR1:  rdata = adr_q[15:8];
      RA_ADR2:  rdata = adr_q[23:16];
      RA_ADR3:  rdata = adr_q[31:24];
      default:  rdata = 8'd0;
    endcase
  end

  assign op_type   = type_q;
  assign card_addr = adr_q;
  assign clk_div   = cdiv_q;
  assign dbyte     = db_q;

endmodule

// File: rtl/sd_spi_seq_frame.sv
`timescale 1ns/1ps
module sd_spi_seq_frame
  import sd_spi_seq_pkg::*;
(
  input  st_e         st,
  input  logic [2:0]  idx,
  input  op_e         op,
  input  logic [31:0] arg,
  input  logic [7:0]  dbyte,
  input  logic [7:0]  txd,
  output logic [7:0]  byte_out
);

  logic [5:0]  cmd_idx;
  logic [31:0] arg_eff;
  logic [7:0]  crc;

  always_comb begin
    case (op)
      OP_WRITE: cmd_idx = 6'd24;
      OP_READ:  cmd_idx = 6'd17;
      default:  cmd_idx = 6'd0;
    endcase
    arg_eff = (op == OP_INIT) ? 32'd0 : arg;
    crc     = (op == OP_INIT) ? 8'h95 : FILL_BYTE;
  end

  always_comb begin
    case (st)
      S_CMD: begin
        case (idx)
          3'd0:    byte_out = {2'b01, cmd_idx};
          3'd1:    byte_out = arg_eff[31:24];
          3'd2:    byte_out = arg_eff[23:16];
          3'd3:    byte_out = arg_eff[15:8];
          3'd4:    byte_out = arg_eff[7:0];
          default: byte_out = crc;
        endcase
      end
      S_DIRECT: byte_out = dbyte;
      S_WTOK:   byte_out = DATA_TOKEN;
      S_WDATA:  byte_out = txd;
      default:  byte_out = FILL_BYTE;
    endcase
  end

endmodule

// File: rtl/sd_spi_seq_fsm.sv
`timescale 1ns/1ps
module sd_spi_seq_fsm
  import sd_spi_seq_pkg::*;
#(
  parameter int BLK_BYTES  = 512,
  parameter int MAX_POLL   = 16,
  parameter int INIT_TRIES = 8,
  parameter int BUSY_POLL  = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  op_e         op_in,
  input  logic [31:0] addr_in,
  input  logic [7:0]  db_in,
  input  logic        spi_done,
  input  logic [7:0]  spi_rx,
  input  logic        txf_empty,
  output logic        spi_go,
  output logic        txf_pop,
  output logic        rxf_push,
  output logic        busy,
  output logic        err_we,
  output op_e         err_op,
  output logic [1:0]  err_code,
  output st_e         st_q,
  output logic [2:0]  frame_idx,
  output op_e         op_q,
  output logic [31:0] arg_q,
  output logic [7:0]  db_q
);

  localparam int M1      = (BLK_BYTES > MAX_POLL) ? BLK_BYTES : MAX_POLL;
  localparam int CNT_MAX = (M1 > BUSY_POLL) ? M1 : BUSY_POLL;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int TW      = $clog2(INIT_TRIES + 1);
  localparam logic [CW-1:0] POLL_LAST = CW'(MAX_POLL - 1);
  localparam logic [CW-1:0] BLK_LAST  = CW'(BLK_BYTES - 1);
  localparam logic [CW-1:0] BUSY_LAST = CW'(BUSY_POLL - 1);
  localparam logic [CW-1:0] FRM_LAST  = CW'(5);
  localparam logic [CW-1:0] CRC_LAST  = CW'(1);
  localparam logic [TW-1:0] TRY_LAST  = TW'(INIT_TRIES - 1);

  st_e           st_n;
  op_e           op_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [TW-1:0] try_q, try_n;
  logic          fly_q, fly_n;
  logic [31:0]   arg_n;
  logic [7:0]    db_n;
  logic          fin;
  logic [1:0]    code;

  always_comb begin
    st_n = st_q;  op_n = op_q;  cnt_n = cnt_q;  try_n = try_q;
    fly_n = fly_q;  arg_n = arg_q;  db_n = db_q;
    spi_go = 1'b0;  txf_pop = 1'b0;  rxf_push = 1'b0;
    fin = 1'b0;  code = EC_OK;
    if (st_q == S_IDLE) begin
      if (start) begin
        op_n  = op_in;
        arg_n = addr_in;
        db_n  = db_in;
        cnt_n = '0;
        try_n = '0;
        st_n  = (op_in == OP_DIRECT) ? S_DIRECT : S_CMD;
      end
    end else if (!fly_q) begin
      if (!(st_q == S_WDATA && txf_empty)) begin
        spi_go  = 1'b1;
        fly_n   = 1'b1;
        txf_pop = (st_q == S_WDATA);
      end
    end else if (spi_done) begin
      fly_n = 1'b0;
      case (st_q)
        S_DIRECT: fin = 1'b1;
        S_CMD: begin
          if (cnt_q == FRM_LAST) begin st_n = S_RESP; cnt_n = '0; end
          else cnt_n = cnt_q + 1'b1;
        end
        S_RESP: begin
          if (spi_rx == FILL_BYTE) begin
            if (cnt_q == POLL_LAST) begin fin = 1'b1; code = EC_TIMEOUT; end
            else cnt_n = cnt_q + 1'b1;
          end else if (op_q == OP_INIT && spi_rx == RESP_IDLE) begin
            if (try_q == TRY_LAST) begin fin = 1'b1; code = EC_DATA; end
            else begin try_n = try_q + 1'b1; st_n = S_CMD; cnt_n = '0; end
          end else if (spi_rx != RESP_READY) begin
            fin = 1'b1; code = EC_REJECT;
          end else if (op_q == OP_WRITE) begin
            st_n = S_WTOK; cnt_n = '0;
          end else if (op_q == OP_READ) begin
            st_n = S_RTOK; cnt_n = '0;
          end else begin
            fin = 1'b1;
          end
        end
        S_WTOK: begin st_n = S_WDATA; cnt_n = '0; end
        S_WDATA: begin
          if (cnt_q == BLK_LAST) begin st_n = S_WCRC; cnt_n = '0; end
          else cnt_n = cnt_q + 1'b1;
        end
        S_WCRC: begin
          if (cnt_q == CRC_LAST) begin st_n = S_WDRESP; cnt_n = '0; end
          else cnt_n = cnt_q + 1'b1;
        end
        S_WDRESP: begin
          if (spi_rx == FILL_BYTE) begin
            if (cnt_q == POLL_LAST) begin fin = 1'b1; code = EC_TIMEOUT; end
            else cnt_n = cnt_q + 1'b1;
          end else if (spi_rx[4:0] == 5'b00101) begin
            st_n = S_WBUSY; cnt_n = '0;
          end else begin
            fin = 1'b1; code = EC_DATA;
          end
        end
        S_WBUSY: begin
          if (spi_rx == RESP_READY) begin
            if (cnt_q == BUSY_LAST) begin fin = 1'b1; code = EC_TIMEOUT; end
            else cnt_n = cnt_q + 1'b1;
          end else begin
            fin = 1'b1;
          end
        end
        S_RTOK: begin
          if (spi_rx == FILL_BYTE) begin
            if (cnt_q == POLL_LAST) begin fin = 1'b1; code = EC_TIMEOUT; end
            else cnt_n = cnt_q + 1'b1;
          end else if (spi_rx == DATA_TOKEN) begin
            st_n = S_RDATA; cnt_n = '0;
          end else begin
            fin = 1'b1; code = EC_DATA;
          end
        end
        S_RDATA: begin
          rxf_push = 1'b1;
          if (cnt_q == BLK_LAST) begin st_n = S_RCRC; cnt_n = '0; end
          else cnt_n = cnt_q + 1'b1;
        end
        S_RCRC: begin
          if (cnt_q == CRC_LAST) fin = 1'b1;
          else cnt_n = cnt_q + 1'b1;
        end
        default: st_n = S_IDLE;
      endcase
    end
    if (fin) st_n = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      op_q  <= OP_DIRECT;
      cnt_q <= '0;
      try_q <= '0;
      fly_q <= 1'b0;
      arg_q <= '0;
      db_q  <= '0;
    end else begin
      st_q  <= st_n;
      op_q  <= op_n;
      cnt_q <= cnt_n;
      try_q <= try_n;
      fly_q <= fly_n;
      arg_q <= arg_n;
      db_q  <= db_n;
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign err_we    = fin && (op_q != OP_DIRECT);
  assign err_op    = op_q;
  assign err_code  = code;
  assign frame_idx = cnt_q[2:0];

endmodule

// File: rtl/sd_spi_seq.sv
`timescale 1ns/1ps
module sd_spi_seq
  import sd_spi_seq_pkg::*;
#(
  parameter int BLK_BYTES  = 512,
  parameter int MAX_POLL   = 16,
  parameter int INIT_TRIES = 8,
  parameter int BUSY_POLL  = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_cs_n,
  output logic [7:0] spi_clk_div,
  output logic       spi_go,
  output logic [7:0] spi_tx,
  input  logic       spi_done,
  input  logic [7:0] spi_rx,
  input  logic       txf_empty,
  input  logic [7:0] txf_data,
  output logic       txf_pop,
  output logic       rxf_push,
  output logic [7:0] rxf_data
);

  logic [1:0]  rst_sync;
  logic        rst_s;
  logic        busy, start, err_we;
  op_e         op_type, err_op, op_q;
  st_e         st_q;
  logic [1:0]  err_code;
  logic [31:0] card_addr, arg_q;
  logic [7:0]  dbyte, db_q;
  logic [5:0]  err_q;
  logic [2:0]  frame_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  sd_spi_seq_regs u_regs (
    .clk(clk), .rst_n(rst_s), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .err_we(err_we), .err_op(err_op),
    .err_code(err_code), .op_type(op_type), .card_addr(card_addr),
    .clk_div(spi_clk_div), .dbyte(dbyte), .start(start), .err_q(err_q)
  );

  sd_spi_seq_fsm #(
    .BLK_BYTES(BLK_BYTES), .MAX_POLL(MAX_POLL),
    .INIT_TRIES(INIT_TRIES), .BUSY_POLL(BUSY_POLL)
  ) u_fsm (
    .clk(clk), .rst_n(rst_s), .start(start), .op_in(op_type),
    .addr_in(card_addr), .db_in(dbyte), .spi_done(spi_done), .spi_rx(spi_rx),
    .txf_empty(txf_empty), .spi_go(spi_go), .txf_pop(txf_pop),
    .rxf_push(rxf_push), .busy(busy), .err_we(err_we), .err_op(err_op),
    .err_code(err_code), .st_q(st_q), .frame_idx(frame_idx), .op_q(op_q),
    .arg_q(arg_q), .db_q(db_q)
  );

  sd_spi_seq_frame u_frame (
    .st(st_q), .idx(frame_idx), .op(op_q), .arg(arg_q), .dbyte(db_q),
    .txd(txf_data), .byte_out(spi_tx)
  );

  assign spi_cs_n = !busy;
  assign rxf_data = spi_rx;

endmodule

// File: rtl/sd_spi_seq_chk.sv
`timescale 1ns/1ps
module sd_spi_seq_chk (
  input logic       clk,
  input logic       rst_s,
  input logic       reg_we,
  input logic [3:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       busy,
  input logic       spi_go,
  input logic       spi_cs_n,
  input logic       txf_pop,
  input logic       txf_empty,
  input logic       rxf_push,
  input logic [5:0] err_q
);

  assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_we && reg_addr == 4'd1 && reg_wdata[0] && !busy) |=> busy);

  assert_go_with_select_R5: assert property (@(posedge clk) disable iff (!rst_s)
    spi_go |-> !spi_cs_n);

  assert_single_flight_R4: assert property (@(posedge clk) disable iff (!rst_s)
    spi_go |=> !spi_go);

  assert_push_with_select_R10: assert property (@(posedge clk) disable iff (!rst_s)
    rxf_push |-> !spi_cs_n);

  assert_no_pop_empty_R12: assert property (@(posedge clk) disable iff (!rst_s)
    txf_pop |-> !txf_empty);

  assert_err_only_at_end_R11: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(err_q) |-> $fell(busy));

endmodule

bind sd_spi_seq sd_spi_seq_chk u_chk (
  .clk(clk), .rst_s(rst_s), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .spi_go(spi_go), .spi_cs_n(spi_cs_n),
  .txf_pop(txf_pop), .txf_empty(txf_empty), .rxf_push(rxf_push), .err_q(err_q)
);

// File: tb/sd_spi_seq_bench.sv
`timescale 1ns/1ps
module sd_spi_seq_bench;

  localparam int SC_FF = 0, SC_INIT_OK = 1, SC_INIT_REJ = 2, SC_INIT_TRY = 3;
  localparam int SC_WR_OK = 4, SC_WR_REJ = 5, SC_WR_DREJ = 6, SC_WR_BTO = 7;
  localparam int SC_RD_OK = 8, SC_RD_ETOK = 9, SC_RD_TO = 10;

  // {address, write data, expected readback}
  localparam logic [19:0] REGV [0:7] = '{
    {4'd4,  8'h10, 8'h10}, {4'd8,  8'h78, 8'h78}, {4'd9,  8'h56, 8'h56},
    {4'd10, 8'h34, 8'h34}, {4'd11, 8'h12, 8'h12}, {4'd5,  8'h5F, 8'h5F},
    {4'd0,  8'hFF, 8'h03}, {4'd1,  8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       spi_cs_n, spi_go, txf_pop, rxf_push;
  logic [7:0] spi_clk_div, spi_tx, rxf_data;
  logic       spi_done = 1'b0;
  logic [7:0] spi_rx = 8'hFF;
  logic       txf_empty = 1'b0;
  logic [7:0] txf_data;

  integer total = 0, bad = 0;
  integer k = 0, base = 0, rxn = 0, rxbase = 0, tx_ptr = 0, txbase = 0;
  integer sc = SC_FF;
  logic [7:0] tx_log [0:1023];
  logic [7:0] rx_got [0:1023];
  logic [7:0] rv;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  assign txf_data = tx_ptr[7:0];

  sd_spi_seq #(.BUSY_POLL(32)) u_sd_spi_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_clk_div(spi_clk_div), .spi_go(spi_go), .spi_tx(spi_tx),
    .spi_done(spi_done), .spi_rx(spi_rx), .txf_empty(txf_empty),
    .txf_data(txf_data), .txf_pop(txf_pop), .rxf_push(rxf_push),
    .rxf_data(rxf_data)
  );

  function automatic logic [7:0] card_rx(input integer s, input integer o);
    case (s)
      SC_INIT_OK:  return (o == 7) ? 8'h01 : (o == 14) ? 8'h00 : 8'hFF;
      SC_INIT_REJ: return (o == 6) ? 8'h05 : 8'hFF;
      SC_INIT_TRY: return (o % 7 == 6) ? 8'h01 : 8'hFF;
      SC_WR_OK:    return (o == 6 || o == 524 || o == 525) ? 8'h00 :
                          (o == 523) ? 8'hE5 : 8'hFF;
      SC_WR_REJ:   return (o == 6) ? 8'h04 : 8'hFF;
      SC_WR_DREJ:  return (o == 6) ? 8'h00 : (o == 522) ? 8'h0B : 8'hFF;
      SC_WR_BTO:   return (o == 6 || o > 522) ? 8'h00 : (o == 522) ? 8'h05 : 8'hFF;
      SC_RD_OK:    return (o == 6) ? 8'h00 : (o == 8) ? 8'hFE :
                          (o >= 9 && o <= 520) ? 8'((o * 3) & 255) :
                          (o == 521 || o == 522) ? 8'hAB : 8'hFF;
      SC_RD_ETOK:  return (o == 6) ? 8'h00 : (o == 7) ? 8'h09 : 8'hFF;
      SC_RD_TO:    return (o == 6) ? 8'h00 : 8'hFF;
      default:     return 8'hFF;
    endcase
  endfunction

  // byte-link shifter, card and FIFO model
  always @(posedge clk) begin
    spi_done <= 1'b0;
    if (spi_go) begin
      tx_log[k % 1024] <= spi_tx;
      spi_rx   <= card_rx(sc, k - base);
      spi_done <= 1'b1;
      k <= k + 1;
    end
    if (rxf_push) begin
      rx_got[rxn % 1024] <= rxf_data;
      rxn <= rxn + 1;
    end
    if (txf_pop) tx_ptr <= tx_ptr + 1;
  end

  task automatic chk(input string tag, input integer act, input integer exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 4'd2;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic begin_op(input integer s, input logic [7:0] typ);
    wr(4'd0, typ);
    @(negedge clk);
    sc = s; base = k; rxbase = rxn; txbase = tx_ptr;
    wr(4'd1, 8'h01);
  endtask

  task automatic wait_idle();
    integer n;
    n = 0;
    reg_addr = 4'd2;
    @(negedge clk);
    #1;
    while (reg_rdata[0] && n < 20000) begin
      @(negedge clk);
      #1;
      n++;
    end
    if (n >= 20000) chk("wait_idle timeout", 1, 0);
  endtask

  task automatic run(input integer s, input logic [7:0] typ);
    begin_op(s, typ);
    wait_idle();
  endtask

  initial begin
    #(5.0 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    integer mism;
    repeat (5) @(negedge clk);
    #1;
    chk("R1 cs_n in reset", spi_cs_n, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd2, rv); chk("R1 status after reset", rv, 0);
    rd(4'd3, rv); chk("R1 error after reset", rv, 0);
    chk("R1 clk div after reset", spi_clk_div, 0);
    chk("R1 cs_n after reset", spi_cs_n, 1);

    foreach (REGV[i]) begin
      wr(REGV[i][19:16], REGV[i][15:8]);
      rd(REGV[i][19:16], rv);
      chk($sformatf("R2 readback addr %0d", REGV[i][19:16]), rv, REGV[i][7:0]);
    end
    chk("R2 clk div port", spi_clk_div, 8'h10);
    rd(4'd2, rv); chk("R3 ctrl write of 0 does not start", rv, 0);

    // direct
    run(SC_FF, 8'd0);
    chk("R4 direct byte count", k - base, 1);
    chk("R4 direct byte value", tx_log[base % 1024], 8'h5F);
    rd(4'd3, rv); chk("R4 error unchanged", rv, 0);

    // init
    run(SC_INIT_OK, 8'd1);
    chk("R6 init retry byte count", k - base, 15);
    chk("R5 init cmd byte", tx_log[base % 1024], 8'h40);
    chk("R5 init zero argument", {tx_log[(base+1)%1024], tx_log[(base+4)%1024]}, 0);
    chk("R5 init crc byte", tx_log[(base+5) % 1024], 8'h95);
    chk("R5 poll byte", tx_log[(base+6) % 1024], 8'hFF);
    chk("R6 resent frame", tx_log[(base+8) % 1024], 8'h40);
    rd(4'd3, rv); chk("R6 init ok code", rv, 0);
    run(SC_INIT_REJ, 8'd1);
    rd(4'd3, rv); chk("R6 init reject code", rv, 8'h02);
    chk("R6 init reject count", k - base, 7);
    run(SC_INIT_TRY, 8'd1);
    rd(4'd3, rv); chk("R6 init tries code", rv, 8'h03);
    chk("R6 eight frames", k - base, 56);
    run(SC_FF, 8'd1);
    rd(4'd3, rv); chk("R7 init timeout code", rv, 8'h01);
    chk("R7 16 polls", k - base, 22);

    // write with FIFO stall and a start while busy
    txf_empty = 1'b1;
    begin_op(SC_WR_OK, 8'd2);
    repeat (100) @(negedge clk);
    #1;
    chk("R12 stalled at first data byte", k - base, 8);
    chk("R12 no pop while empty", tx_ptr - txbase, 0);
    chk("R5 cs held during stall", spi_cs_n, 0);
    rd(4'd2, rv); chk("R3 busy during op", rv, 1);
    wr(4'd0, 8'd3);
    wr(4'd1, 8'h01);
    txf_empty = 1'b0;
    wait_idle();
    chk("R3 start while busy ignored", k - base, 527);
    chk("R5 write cmd byte", tx_log[base % 1024], 8'h58);
    chk("R5 address msb first", {tx_log[(base+1)%1024], tx_log[(base+2)%1024],
        tx_log[(base+3)%1024], tx_log[(base+4)%1024]}, 32'h12345678);
    chk("R5 write crc", tx_log[(base+5) % 1024], 8'hFF);
    chk("R8 start token", tx_log[(base+7) % 1024], 8'hFE);
    mism = 0;
    for (int i = 0; i < 512; i++)
      if (tx_log[(base+8+i) % 1024] != 8'((txbase + i) & 255)) mism++;
    chk("R8 512 data bytes in order", mism, 0);
    chk("R8 crc fill", {tx_log[(base+520)%1024], tx_log[(base+521)%1024]}, 16'hFFFF);
    chk("R8 pops", tx_ptr - txbase, 512);
    rd(4'd3, rv); chk("R9 R11 write ok keeps init field", rv, 8'h01);
    chk("R5 cs released", spi_cs_n, 1);

    run(SC_WR_REJ, 8'd2);
    rd(4'd3, rv); chk("R8 cmd reject code", rv, 8'h21);
    run(SC_WR_DREJ, 8'd2);
    rd(4'd3, rv); chk("R8 data reject code", rv, 8'h31);
    chk("R8 data reject count", k - base, 523);
    run(SC_WR_BTO, 8'd2);
    rd(4'd3, rv); chk("R9 busy timeout code", rv, 8'h11);
    chk("R9 busy poll count", k - base, 555);

    // read
    run(SC_RD_OK, 8'd3);
    chk("R5 read cmd byte", tx_log[base % 1024], 8'h51);
    chk("R10 read byte count", k - base, 523);
    chk("R10 pushes", rxn - rxbase, 512);
    mism = 0;
    for (int i = 0; i < 512; i++)
      if (rx_got[(rxbase + i) % 1024] != 8'(((9 + i) * 3) & 255)) mism++;
    chk("R10 pushed data", mism, 0);
    rd(4'd3, rv); chk("R10 R11 read ok", rv, 8'h11);
    run(SC_RD_ETOK, 8'd3);
    rd(4'd3, rv); chk("R10 R11 error token code", rv, 8'h1D);
    chk("R10 no push on error", rxn - rxbase, 0);
    run(SC_RD_TO, 8'd3);
    rd(4'd3, rv); chk("R7 token timeout code", rv, 8'h15);
    chk("R7 token polls", k - base, 23);

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule